// File: doc/BRIEF.md
# NOR Flash Program and Sector-Erase Sequencer

This block sits on the host side of a parallel NOR flash bus. It takes one request at a time over a valid/ready interface. A request is either a single-word program or a sector erase. The block turns the request into the flash's command protocol: unlock writes, a command code, then the target write. Each of these is a separate bus write cycle, shaped so that the address is settled before write-enable falls and the data is still held when it rises. Low time, high time and the idle gap between cycles are parameter cycle counts.

Once the command is in, the flash runs its embedded algorithm without help from the host. The sequencer only has to notice when that algorithm ends. A per-request mode bit selects how it does this:
- **Toggle mode** reads status from the target address again and again until two back-to-back reads agree on the toggle bit.
- **Busy mode** watches the flash's busy output until it drops.

No verify read follows. If neither condition appears within a cycle budget, the block holds the flash's reset low to force it back to read mode. It then reports the request as finished with an error.

Top module: `flash_seq`

## Requirements
- R1: A program request (req_op=0) produces exactly four bus writes, as word address/data: 0x555/0x00AA, 0x2AA/0x0055, 0x555/0x00A0, then req_addr/req_data.
- R2: An erase request (req_op=1) produces exactly six bus writes: 0x555/0x00AA, 0x2AA/0x0055, 0x555/0x0080, 0x555/0x00AA, 0x2AA/0x0055, then req_addr/0x0030.
- R3: In every write cycle, chip-enable is low and the address is unchanged for at least one clock before write-enable falls. Address and data are unchanged across the clock in which write-enable rises, with the data driver still enabled. Write-enable and output-enable are never low together.
- R4: In toggle mode (req_mode=0), the block reads status at req_addr and compares bit 6 of each read with the previous one. It finishes on the first match, so a flash that toggles K times (K≥1) sees K+1 reads, and one that never toggles sees 2.
- R5: In busy mode (req_mode=1), the block issues no status reads. It finishes once fl_busy (active high) is seen low after a guard of BUSY_GUARD cycles.
- R6: A normal completion reports done_err=0, and no further bus strobe follows: no verify read and no extra write.
- R7: If completion is not seen within TIMEOUT cycles, fl_rst_n goes low for exactly RST_CYC cycles with no bus strobe during it, and the request then finishes with done_err=1.
- R8: req_ready is high only while idle. A req_valid presented while req_ready is low is ignored: it starts no bus cycles and does not alter the request in flight.
- R9: done_valid is a single-cycle pulse, and req_ready is high in the cycle after it.
- R10: Out of reset: req_ready=1, done_valid=0, and fl_ce_n, fl_we_n, fl_oe_n and fl_rst_n are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| req_valid | input | 1 | Request present |
| req_op | input | 1 | 0 = word program, 1 = sector erase |
| req_mode | input | 1 | 0 = toggle-bit polling, 1 = busy-pin wait |
| req_addr | input | AW | Target word address (sector address for erase) |
| req_data | input | DW | Word to program |
| req_ready | output | 1 | Idle and able to accept a request |
| done_valid | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion was a timeout abort |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | DW | Flash data driven out |
| fl_dq_oe | output | 1 | Data driver enable |
| fl_dq_in | input | DW | Flash data read back |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_rst_n | output | 1 | Flash hardware reset, active low |
| fl_busy | input | 1 | Flash busy indication, active high |

## Verification
Each result is due at a known point after its stimulus:
- A request presented at one falling edge is taken at the next rising edge, and its first chip-enable appears one cycle later.
- Write-enable falls one cycle after chip-enable.
- done_valid follows the final status read, the busy drop, or the last reset cycle. It lasts one cycle, and req_ready is due in the next cycle.

The bench samples only on falling clock edges. Its flash model compares each strobe edge against the values held one sample earlier, and counts writes, reads, reset cycles and stray strobes. Every end-of-request check is made at the falling edge where done_valid is first seen high, or at the edge after it for R9. A fixed post-done window then confirms that the bus stays quiet.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

    typedef enum logic [2:0] {
        BC_IDLE,
        BC_SETUP,
        BC_STROBE,
        BC_HOLD,
        BC_GAP
    } bus_state_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CMD,
        SQ_POLL,
        SQ_WAIT_BUSY,
        SQ_RESET,
        SQ_DONE
    } seq_state_t;

    localparam logic [7:0] CODE_KEY1    = 8'hAA;
    localparam logic [7:0] CODE_KEY2    = 8'h55;
    localparam logic [7:0] CODE_PROGRAM = 8'hA0;
    localparam logic [7:0] CODE_ERASE   = 8'h80;
    localparam logic [7:0] CODE_SECTOR  = 8'h30;

endpackage

// File: rtl/flseq_bus.sv
module flseq_bus
    import flseq_pkg::*;
#(
    parameter int AW      = 23,
    parameter int DW      = 16,
    parameter int WE_LO   = 2,
    parameter int WE_HI   = 1,
    parameter int GAP     = 1,
    parameter int RD_LO   = 2,
    parameter int TGL_BIT = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          cyc_done,
    output logic          rd_tgl,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [DW-1:0] fl_dq_in,
    output logic          fl_we_n,
    output logic          fl_oe_n,
    output logic          fl_ce_n
);
    localparam int M1   = (WE_LO > RD_LO) ? WE_LO : RD_LO;
    localparam int M2   = (WE_HI > GAP) ? WE_HI : GAP;
    localparam int MAXC = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        bus_state_t    st;
        logic          rd;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [CW-1:0] cnt;
        logic          done;
    } bus_reg_t;

    bus_reg_t bus_q, bus_d;

    always_comb begin
        bus_d      = bus_q;
        bus_d.done = 1'b0;
        case (bus_q.st)
            BC_IDLE: begin
                if (start) begin
                    bus_d.st = BC_SETUP;
                    bus_d.rd = rd;
                    bus_d.a  = addr;
                    bus_d.d  = wdata;
                end
            end
            BC_SETUP: begin
                bus_d.st  = BC_STROBE;
                bus_d.cnt = bus_q.rd ? CW'(RD_LO - 1) : CW'(WE_LO - 1);
            end
            BC_STROBE: begin
                if (bus_q.cnt == '0) begin
                    bus_d.st  = BC_HOLD;
                    bus_d.cnt = CW'(WE_HI - 1);
                    if (bus_q.rd) bus_d.d = fl_dq_in;
                end else begin
                    bus_d.cnt = bus_q.cnt - 1'b1;
                end
            end
            BC_HOLD: begin
                if (bus_q.cnt == '0) begin
                    bus_d.st  = BC_GAP;
                    bus_d.cnt = CW'(GAP - 1);
                end else begin
                    bus_d.cnt = bus_q.cnt - 1'b1;
                end
            end
            BC_GAP: begin
                if (bus_q.cnt == '0) begin
                    bus_d.st   = BC_IDLE;
                    bus_d.done = 1'b1;
                end else begin
                    bus_d.cnt = bus_q.cnt - 1'b1;
                end
            end
            default: bus_d.st = BC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '{st: BC_IDLE, rd: 1'b0, a: '0, d: '0, cnt: '0, done: 1'b0};
        end else begin
            bus_q <= bus_d;
        end
    end

    assign cyc_done  = bus_q.done;
    assign rd_tgl    = bus_q.d[TGL_BIT];
    assign fl_addr   = bus_q.a;
    assign fl_dq_out = bus_q.d;
    assign fl_ce_n   = !(bus_q.st == BC_SETUP || bus_q.st == BC_STROBE || bus_q.st == BC_HOLD);
    assign fl_we_n   = !(bus_q.st == BC_STROBE && !bus_q.rd);
    assign fl_oe_n   = !(bus_q.st == BC_STROBE && bus_q.rd);
    assign fl_dq_oe  = !bus_q.rd && (bus_q.st == BC_SETUP || bus_q.st == BC_STROBE || bus_q.st == BC_HOLD);

    AST_ADDR_HELD_WE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n) |-> $stable(fl_addr)) else $error("address moved while write-enable low"); // R3
    AST_DATA_HELD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> ($stable(fl_dq_out) && fl_dq_oe)) else $error("data moved at write-enable rise"); // R3
    AST_CE_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_we_n) |-> $past(!fl_ce_n)) else $error("chip enable not set up before write-enable"); // R3
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (bus_q.st == BC_IDLE)) else $error("bus cycle started while busy"); // R3

endmodule

// File: rtl/flseq_ctrl.sv
module flseq_ctrl
    import flseq_pkg::*;
#(
    parameter int          AW         = 23,
    parameter int          DW         = 16,
    parameter int          TIMEOUT    = 100000,
    parameter int          RST_CYC    = 8,
    parameter int          BUSY_GUARD = 4,
    parameter logic [AW-1:0] KEY_ADDR1 = AW'(12'h555),
    parameter logic [AW-1:0] KEY_ADDR2 = AW'(12'h2AA)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_op,
    input  logic          req_mode,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          req_ready,
    output logic          done_valid,
    output logic          done_err,
    output logic          bus_start,
    output logic          bus_rd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_cyc_done,
    input  logic          bus_tgl,
    input  logic          fl_busy,
    output logic          fl_rst_n
);
    localparam int TW = $clog2(TIMEOUT + 1);
    localparam int RW = $clog2(RST_CYC + 1);
    localparam int GW = $clog2(BUSY_GUARD + 1);

    typedef struct packed {
        seq_state_t    st;
        logic          erase;
        logic          mode;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [2:0]    step;
        logic          pend;
        logic          prev;
        logic          have_prev;
        logic [TW-1:0] tmr;
        logic [RW-1:0] rcnt;
        logic [GW-1:0] gcnt;
        logic          err;
        logic          busy_s;
    } seq_reg_t;

    seq_reg_t sq_q, sq_d;

    function automatic logic [AW+DW-1:0] seq_word(input logic erase, input logic [2:0] step,
                                                  input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [AW+DW-1:0] w;
        case (step)
            3'd0:    w = {KEY_ADDR1, DW'(CODE_KEY1)};
            3'd1:    w = {KEY_ADDR2, DW'(CODE_KEY2)};
            3'd2:    w = {KEY_ADDR1, erase ? DW'(CODE_ERASE) : DW'(CODE_PROGRAM)};
            3'd3:    w = erase ? {KEY_ADDR1, DW'(CODE_KEY1)} : {a, d};
            3'd4:    w = {KEY_ADDR2, DW'(CODE_KEY2)};
            default: w = {a, DW'(CODE_SECTOR)};
        endcase
        return w;
    endfunction

    logic             timed_out;
    logic [2:0]       last_step;
    logic [AW+DW-1:0] cur_word;

    assign timed_out = (sq_q.tmr == TW'(TIMEOUT));
    assign last_step = sq_q.erase ? 3'd5 : 3'd3;
    assign cur_word  = seq_word(sq_q.erase, sq_q.step, sq_q.a, sq_q.d);

    always_comb begin
        sq_d        = sq_q;
        sq_d.busy_s = fl_busy;
        if ((sq_q.st == SQ_POLL || sq_q.st == SQ_WAIT_BUSY) && !timed_out) begin
            sq_d.tmr = sq_q.tmr + 1'b1;
        end
        case (sq_q.st)
            SQ_IDLE: begin
                if (req_valid) begin
                    sq_d.st    = SQ_CMD;
                    sq_d.erase = req_op;
                    sq_d.mode  = req_mode;
                    sq_d.a     = req_addr;
                    sq_d.d     = req_data;
                    sq_d.step  = '0;
                    sq_d.pend  = 1'b0;
                    sq_d.err   = 1'b0;
                end
            end
            SQ_CMD: begin
                if (!sq_q.pend) begin
                    sq_d.pend = 1'b1;
                end else if (bus_cyc_done) begin
                    sq_d.pend = 1'b0;
                    if (sq_q.step == last_step) begin
                        sq_d.st        = sq_q.mode ? SQ_WAIT_BUSY : SQ_POLL;
                        sq_d.tmr       = '0;
                        sq_d.gcnt      = '0;
                        sq_d.have_prev = 1'b0;
                    end else begin
                        sq_d.step = sq_q.step + 1'b1;
                    end
                end
            end
            SQ_POLL: begin
                if (!sq_q.pend) begin
                    if (timed_out) begin
                        sq_d.st   = SQ_RESET;
                        sq_d.rcnt = RW'(RST_CYC - 1);
                    end else begin
                        sq_d.pend = 1'b1;
                    end
                end else if (bus_cyc_done) begin
                    sq_d.pend = 1'b0;
                    if (sq_q.have_prev && (bus_tgl == sq_q.prev)) begin
                        sq_d.st = SQ_DONE;
                    end else begin
                        sq_d.prev      = bus_tgl;
                        sq_d.have_prev = 1'b1;
                    end
                end
            end
            SQ_WAIT_BUSY: begin
                if (sq_q.gcnt != GW'(BUSY_GUARD)) begin
                    sq_d.gcnt = sq_q.gcnt + 1'b1;
                end else if (!sq_q.busy_s) begin
                    sq_d.st = SQ_DONE;
                end else if (timed_out) begin
                    sq_d.st   = SQ_RESET;
                    sq_d.rcnt = RW'(RST_CYC - 1);
                end
            end
            SQ_RESET: begin
                if (sq_q.rcnt == '0) begin
                    sq_d.st  = SQ_DONE;
                    sq_d.err = 1'b1;
                end else begin
                    sq_d.rcnt = sq_q.rcnt - 1'b1;
                end
            end
            SQ_DONE: sq_d.st = SQ_IDLE;
            default: sq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '{st: SQ_IDLE, erase: 1'b0, mode: 1'b0, a: '0, d: '0, step: '0,
                      pend: 1'b0, prev: 1'b0, have_prev: 1'b0, tmr: '0, rcnt: '0,
                      gcnt: '0, err: 1'b0, busy_s: 1'b0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign bus_start  = !sq_q.pend && (sq_q.st == SQ_CMD || (sq_q.st == SQ_POLL && !timed_out));
    assign bus_rd     = (sq_q.st == SQ_POLL);
    assign bus_addr   = bus_rd ? sq_q.a : cur_word[AW+DW-1:DW];
    assign bus_wdata  = cur_word[DW-1:0];
    assign req_ready  = (sq_q.st == SQ_IDLE);
    assign done_valid = (sq_q.st == SQ_DONE);
    assign done_err   = sq_q.err;
    assign fl_rst_n   = (sq_q.st != SQ_RESET);

    AST_REQ_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready) |=> ($stable(sq_q.a) && $stable(sq_q.erase) && $stable(sq_q.d))) else $error("request changed mid-operation"); // R8
    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && req_ready)) else $error("done not a single pulse"); // R9
    AST_ERR_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_err) |-> $past(!fl_rst_n)) else $error("error reported without reset pulse"); // R7
    AST_NO_BUS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !bus_start) else $error("bus cycle issued at completion"); // R6

endmodule

// File: rtl/flash_seq.sv
module flash_seq #(
    parameter int AW         = 23,
    parameter int DW         = 16,
    parameter int WE_LO      = 2,
    parameter int WE_HI      = 1,
    parameter int GAP        = 1,
    parameter int RD_LO      = 2,
    parameter int TIMEOUT    = 100000,
    parameter int RST_CYC    = 8,
    parameter int BUSY_GUARD = 4,
    parameter int TGL_BIT    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_op,
    input  logic          req_mode,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          req_ready,
    output logic          done_valid,
    output logic          done_err,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [DW-1:0] fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n,
    output logic          fl_rst_n,
    input  logic          fl_busy
);
    logic          bus_start;
    logic          bus_rd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_cyc_done;
    logic          bus_tgl;

    flseq_ctrl #(
        .AW(AW), .DW(DW), .TIMEOUT(TIMEOUT), .RST_CYC(RST_CYC), .BUSY_GUARD(BUSY_GUARD)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_mode(req_mode),
        .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
        .done_valid(done_valid), .done_err(done_err),
        .bus_start(bus_start), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_cyc_done(bus_cyc_done), .bus_tgl(bus_tgl),
        .fl_busy(fl_busy), .fl_rst_n(fl_rst_n)
    );

    flseq_bus #(
        .AW(AW), .DW(DW), .WE_LO(WE_LO), .WE_HI(WE_HI), .GAP(GAP), .RD_LO(RD_LO), .TGL_BIT(TGL_BIT)
    ) u_bus (
        .clk(clk), .rst_n(rst_n),
        .start(bus_start), .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata),
        .cyc_done(bus_cyc_done), .rd_tgl(bus_tgl),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_ce_n(fl_ce_n)
    );

    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_rst_n) |-> (fl_we_n && fl_oe_n)) else $error("bus strobe during flash reset"); // R7

endmodule

// File: tb/sim_flash_seq.sv
module sim_flash_seq;
    localparam int AW   = 23;
    localparam int DW   = 16;
    localparam int TO   = 300;
    localparam int RSTC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_op = 1'b0, req_mode = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_ready, done_valid, done_err;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dq_out;
    logic          fl_dq_oe;
    logic [DW-1:0] fl_dq_in = '0;
    logic          fl_ce_n, fl_we_n, fl_oe_n, fl_rst_n;
    logic          fl_busy;

    always #4 clk = ~clk;

    flash_seq #(.AW(AW), .DW(DW), .TIMEOUT(TO), .RST_CYC(RSTC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_mode(req_mode),
        .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
        .done_valid(done_valid), .done_err(done_err),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_rst_n(fl_rst_n),
        .fl_busy(fl_busy)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    // flash model state
    int            wr_n, rd_n, viol, rst_low, strobe_in_rst, post_strobes, arm_at, arm_k;
    bit            arm_mode, arm_hang, hang, watch_post, t;
    int            k_left, busy_cnt;
    logic [AW-1:0] wa [16];
    logic [DW-1:0] wd [16];
    logic [AW-1:0] last_ra;
    logic          p_we = 1, p_oe = 1, p_ce = 1;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dq = '0;

    assign fl_busy = hang || (busy_cnt > 0);

    initial begin
        wr_n = 0; rd_n = 0; viol = 0; rst_low = 0; strobe_in_rst = 0; post_strobes = 0;
        arm_at = 99; arm_k = 0; arm_mode = 0; arm_hang = 0; hang = 0; watch_post = 0; t = 0;
        k_left = 0; busy_cnt = 0; last_ra = '0;
    end

    always @(negedge clk) begin
        if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
        if (!fl_rst_n) begin
            rst_low = rst_low + 1;
            if (!fl_we_n || !fl_oe_n) strobe_in_rst = strobe_in_rst + 1;
            hang = 0; k_left = 0; busy_cnt = 0;
        end
        if (p_we && !fl_we_n) begin
            if (fl_addr != p_addr || p_ce) viol = viol + 1;
        end
        if (!p_we && fl_we_n) begin
            if (fl_dq_out != p_dq || fl_addr != p_addr || !fl_dq_oe) viol = viol + 1;
            if (wr_n < 16) begin wa[wr_n] = p_addr; wd[wr_n] = p_dq; end
            wr_n = wr_n + 1;
            if (wr_n == arm_at) begin
                if (arm_hang) hang = 1;
                else if (arm_mode) busy_cnt = arm_k;
                else k_left = arm_k;
            end
        end
        if (!fl_we_n && !fl_oe_n) viol = viol + 1;
        if (p_oe && !fl_oe_n) begin
            rd_n = rd_n + 1;
            last_ra = fl_addr;
            if (hang || k_left > 0) begin
                t = ~t;
                if (!hang) k_left = k_left - 1;
            end
            fl_dq_in = DW'(t) << 6;
        end
        if (watch_post && (!fl_we_n || !fl_oe_n)) post_strobes = post_strobes + 1;
        p_we = fl_we_n; p_oe = fl_oe_n; p_ce = fl_ce_n; p_addr = fl_addr; p_dq = fl_dq_out;
    end

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW+DW-1:0] exp_wr(input bit erase, input int i, input logic [AW-1:0] a,
                                                input logic [DW-1:0] d);
        case (i)
            0: return {AW'(12'h555), 16'h00AA};
            1: return {AW'(12'h2AA), 16'h0055};
            2: return {AW'(12'h555), erase ? 16'h0080 : 16'h00A0};
            3: return erase ? {AW'(12'h555), 16'h00AA} : {a, d};
            4: return {AW'(12'h2AA), 16'h0055};
            default: return {a, 16'h0030};
        endcase
    endfunction

    // vector: op, mode, addr[22:0], data[15:0], k[7:0], hang
    localparam int NV = 7;
    localparam logic [49:0] VEC [NV] = '{
        {1'b0, 1'b0, 23'h012345, 16'hBEEF, 8'd3,  1'b0},
        {1'b0, 1'b0, 23'h7FFFFF, 16'h0000, 8'd0,  1'b0},
        {1'b1, 1'b0, 23'h018000, 16'h0000, 8'd5,  1'b0},
        {1'b0, 1'b1, 23'h000555, 16'h1234, 8'd20, 1'b0},
        {1'b1, 1'b1, 23'h7F8000, 16'h0000, 8'd40, 1'b0},
        {1'b0, 1'b0, 23'h0000AA, 16'h5A5A, 8'd0,  1'b1},
        {1'b1, 1'b1, 23'h400000, 16'h0000, 8'd0,  1'b1}
    };

    task automatic run_op(input bit op, input bit mode, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int k, input bit hng, input bit intrude);
        string rq;
        int    nw, cyc;
        bit    ok, err;
        rq = op ? "R2" : "R1";
        nw = op ? 6 : 4;
        wr_n = 0; rd_n = 0; viol = 0; rst_low = 0; strobe_in_rst = 0; post_strobes = 0; t = 0;
        arm_at = nw; arm_k = k; arm_mode = mode; arm_hang = hng;
        @(negedge clk);
        req_valid = 1; req_op = op; req_mode = mode; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 0;
        if (intrude) begin
            repeat (2) @(negedge clk);
            chk(req_ready == 0, "R8", "ready while busy", req_ready, 0);
            req_valid = 1; req_op = 1; req_addr = 23'h111111; req_data = 16'hFFFF;
            repeat (10) @(negedge clk);
            req_valid = 0;
        end
        cyc = 0;
        while (!done_valid && cyc < 4000) begin @(negedge clk); cyc++; end
        err = done_err;
        chk(done_valid == 1, "R9", "done seen", done_valid, 1);
        chk(wr_n == nw, rq, "write count", wr_n, nw);
        ok = 1;
        for (int i = 0; i < nw && i < 16; i++) if ({wa[i], wd[i]} != exp_wr(op, i, a, d)) ok = 0;
        chk(ok, rq, "write sequence", ok, 1);
        chk(viol == 0, "R3", "strobe timing violations", viol, 0);
        if (mode) chk(rd_n == 0, "R5", "status reads in busy mode", rd_n, 0);
        else if (!hng) begin
            chk(rd_n == ((k < 1 ? 1 : k) + 1), "R4", "status reads", rd_n, (k < 1 ? 1 : k) + 1);
            chk(last_ra == a, "R4", "status read address", last_ra, a);
        end
        if (hng) begin
            chk(err == 1, "R7", "error flag", err, 1);
            chk(rst_low == RSTC, "R7", "reset pulse width", rst_low, RSTC);
            chk(strobe_in_rst == 0, "R7", "strobes in reset", strobe_in_rst, 0);
        end else begin
            chk(err == 0, "R6", "error flag", err, 0);
            chk(rst_low == 0, "R6", "reset pulse", rst_low, 0);
        end
        @(negedge clk);
        chk(done_valid == 0 && req_ready == 1, "R9", "pulse end / ready", {done_valid, req_ready}, 2'b01);
        watch_post = 1;
        repeat (20) @(negedge clk);
        watch_post = 0;
        chk(post_strobes == 0, intrude ? "R8" : "R6", "strobes after done", post_strobes, 0);
        arm_at = 99;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1 && done_valid == 0, "R10", "ready/done at reset", {req_ready, done_valid}, 2'b10);
        chk({fl_ce_n, fl_we_n, fl_oe_n, fl_rst_n} == 4'hF, "R10", "bus idle at reset",
            {fl_ce_n, fl_we_n, fl_oe_n, fl_rst_n}, 4'hF);
        rst_n = 1;
        @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            run_op(VEC[v][49], VEC[v][48], VEC[v][47:25], VEC[v][24:9], int'(VEC[v][8:1]), VEC[v][0], 1'b0);
        end
        // R8: request presented mid-operation must be ignored
        run_op(1'b0, 1'b0, 23'h0ABCDE, 16'hC0DE, 2, 1'b0, 1'b1);
        // R4 corner: single toggle
        run_op(1'b0, 1'b0, 23'h000001, 16'h0001, 1, 1'b0, 1'b0);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule